// File: doc/BRIEF.md
# In-Band Interrupt Command Interpreter

This block sits on the receive path, after the character decoder and before the write port of the receive FIFO. Each decoded character arrives with a flag that marks it as a command or a data character. Two command values are reserved. One raises a registered interrupt level and the other lowers it. The level at the receiving end therefore follows the transitions that the sender placed on its own interrupt input. A host can use this level for back-pressure or for any other signalling that depends on timing.

A policy input decides what happens to the reserved commands after they take effect. With policy 0 they still reach the FIFO. With any other policy they are removed from the stream. The interpreter is active only when the decoder enable and the FIFO enable are both high. When either is low, every character passes through untouched and the interrupt level holds its value. The character stream has one register of latency, and so does the interrupt level.

Top module: `irqcmd_filter`

## Requirements
- R1: During and right after synchronous reset, `intr_level` is 0 and `out_valid` is 0.
- R2: A valid character with `in_is_cmd`=1 and `in_code`=SET_CODE (default 0x00, the command written C0.0, value = y*32 + x), while `dec_en` and `fifo_en` are both 1, drives `intr_level` to 1 on the next clock edge. This also holds when the level is already 1.
- R3: A valid character with `in_is_cmd`=1 and `in_code`=CLR_CODE (default 0x03, the command written C3.0), while the interpreter is active, drives `intr_level` to 0 on the next clock edge.
- R4: While the interpreter is active and `policy` is not 0, a valid SET or CLR command is dropped, and `out_valid` is 0 in the following cycle.
- R5: While the interpreter is active and `policy` is 0, a valid SET or CLR command still acts on `intr_level` and also appears on the outputs one cycle later.
- R6: A data character (`in_is_cmd`=0) carrying the SET or CLR value, and any command with a different value, is forwarded unchanged and leaves `intr_level` unchanged.
- R7: While `dec_en` or `fifo_en` is 0, every valid character is forwarded unchanged and `intr_level` keeps its value.
- R8: A forwarded character appears on `out_valid`, `out_code` and `out_is_cmd` exactly one clock after it is presented. When `in_valid` is 0, `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character strobe from the decoder |
| in_code | input | 8 | Decoded character value |
| in_is_cmd | input | 1 | 1 = command character, 0 = data character |
| dec_en | input | 1 | Decoder enabled |
| fifo_en | input | 1 | Receive FIFO enabled |
| policy | input | POL_W (2) | Discard policy; 0 keeps commands in the stream |
| intr_level | output | 1 | Registered interrupt level |
| out_valid | output | 1 | Write strobe toward the FIFO |
| out_code | output | 8 | Forwarded character value |
| out_is_cmd | output | 1 | Forwarded command flag |

## Verification
The bench builds the block with its default parameters: SET_CODE 0x00, CLR_CODE 0x03 and a 2-bit policy. With these settings every policy value (0 through 3) can be reached, and the random stream can easily hit both reserved codes, with the command flag set and with it clear. Random enables and policies are mixed with directed sequences: setting the level twice, clearing it, sending data characters that alias the reserved values, and toggling an enable in the middle of a command run.

// File: rtl/irqcmd_pkg.sv
package irqcmd_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              is_cmd;
        logic [CHAR_W-1:0] code;
    } char_t;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_SET  = 2'd1,
        DIR_CLR  = 2'd2
    } dir_e;

    function automatic dir_e classify(input char_t ch,
                                      input logic [CHAR_W-1:0] set_code,
                                      input logic [CHAR_W-1:0] clr_code);
        if (!ch.is_cmd)              return DIR_NONE;
        else if (ch.code == set_code) return DIR_SET;
        else if (ch.code == clr_code) return DIR_CLR;
        else                          return DIR_NONE;
    endfunction

endpackage

// File: rtl/irqcmd_decode.sv
module irqcmd_decode
    import irqcmd_pkg::*;
#(
    parameter logic [CHAR_W-1:0] SET_CODE = 8'h00,
    parameter logic [CHAR_W-1:0] CLR_CODE = 8'h03,
    parameter int                POL_W    = 2
) (
    input  logic             in_valid,
    input  char_t            in_char,
    input  logic             dec_en,
    input  logic             fifo_en,
    input  logic [POL_W-1:0] policy,
    output logic             active,
    output dir_e             dir,
    output logic             drop
);
    dir_e raw_dir;

    always_comb begin
        active  = dec_en && fifo_en;
        raw_dir = classify(in_char, SET_CODE, CLR_CODE);
        dir     = (in_valid && active) ? raw_dir : DIR_NONE;
        drop    = (dir != DIR_NONE) && (policy != '0);
    end

    always_comb begin
        assert_drop_only_directive_R4: assert (!drop || (in_valid && in_char.is_cmd));
    end
endmodule

// File: rtl/irqcmd_level.sv
module irqcmd_level
    import irqcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  dir_e dir,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst)                 level <= 1'b0;
        else if (dir == DIR_SET) level <= 1'b1;
        else if (dir == DIR_CLR) level <= 1'b0;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_SET) |=> level);
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_CLR) |=> !level);
    assert_hold_inactive_R7: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(level));
endmodule

// File: rtl/irqcmd_stream.sv
module irqcmd_stream
    import irqcmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  char_t in_char,
    input  logic  drop,
    output logic  out_valid,
    output char_t out_char
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= in_valid && !drop;
            if (in_valid && !drop) out_char <= in_char;
        end
    end

    assert_dropped_gone_R4: assert property (@(posedge clk) disable iff (rst)
        drop |=> !out_valid);
    assert_forward_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !drop) |=> (out_valid && out_char == $past(in_char)));
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/irqcmd_filter.sv
module irqcmd_filter
    import irqcmd_pkg::*;
#(
    parameter logic [CHAR_W-1:0] SET_CODE = 8'h00,
    parameter logic [CHAR_W-1:0] CLR_CODE = 8'h03,
    parameter int                POL_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_code,
    input  logic              in_is_cmd,
    input  logic              dec_en,
    input  logic              fifo_en,
    input  logic [POL_W-1:0]  policy,
    output logic              intr_level,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_code,
    output logic              out_is_cmd
);
    char_t in_char;
    char_t out_char;
    logic  active;
    dir_e  dir;
    logic  drop;

    assign in_char.is_cmd = in_is_cmd;
    assign in_char.code   = in_code;

    irqcmd_decode #(.SET_CODE(SET_CODE), .CLR_CODE(CLR_CODE), .POL_W(POL_W)) u_decode (
        .in_valid (in_valid),
        .in_char  (in_char),
        .dec_en   (dec_en),
        .fifo_en  (fifo_en),
        .policy   (policy),
        .active   (active),
        .dir      (dir),
        .drop     (drop)
    );

    irqcmd_level u_level (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .dir    (dir),
        .level  (intr_level)
    );

    irqcmd_stream u_stream (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_char   (in_char),
        .drop      (drop),
        .out_valid (out_valid),
        .out_char  (out_char)
    );

    assign out_code   = out_char.code;
    assign out_is_cmd = out_char.is_cmd;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!intr_level && !out_valid));
    assert_keep_policy0_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && active && policy == '0) |=> out_valid);
endmodule

// File: tb/irqcmd_filter_tb.sv
module irqcmd_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SETC = 8'h00;
    localparam logic [7:0] CLRC = 8'h03;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_is_cmd, dec_en, fifo_en;
    logic [7:0] in_code;
    logic [1:0] policy;
    logic       intr_level, out_valid, out_is_cmd;
    logic [7:0] out_code;

    int checks = 0;
    int fails  = 0;
    logic m_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqcmd_filter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .in_is_cmd(in_is_cmd), .dec_en(dec_en), .fifo_en(fifo_en),
        .policy(policy), .intr_level(intr_level), .out_valid(out_valid),
        .out_code(out_code), .out_is_cmd(out_is_cmd)
    );

    function automatic bit is_directive(input logic c, input logic [7:0] d);
        return c && (d == SETC || d == CLRC);
    endfunction

    function automatic string tag_of(input logic v, input logic c, input logic [7:0] d,
                                     input logic de, input logic fe, input logic [1:0] p);
        if (!v) return "R8";
        if (!(de && fe)) return "R7";
        if (!is_directive(c, d)) return "R6";
        if (p != 2'd0) return "R4";
        return (d == SETC) ? "R2/R5" : "R3/R5";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic c, input logic [7:0] d,
                        input logic de, input logic fe, input logic [1:0] p);
        logic e_valid;
        string tag;
        @(negedge clk);
        in_valid = v; in_is_cmd = c; in_code = d;
        dec_en = de; fifo_en = fe; policy = p;
        tag = tag_of(v, c, d, de, fe, p);
        e_valid = v;
        if (v && de && fe && is_directive(c, d)) begin
            m_level = (d == SETC);
            if (p != 2'd0) e_valid = 1'b0;
        end
        @(posedge clk); #1;
        check(tag, "intr_level", int'(intr_level), int'(m_level));
        check(tag, "out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            check(tag, "out_code", int'(out_code), int'(d));
            check(tag, "out_is_cmd", int'(out_is_cmd), int'(c));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; in_valid = 0; in_is_cmd = 0; in_code = 0;
        dec_en = 1; fifo_en = 1; policy = 0;
        m_level = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "intr_level", int'(intr_level), 0);
        check("R1", "out_valid", int'(out_valid), 0);
        @(negedge clk); rst = 1'b0;

        // R2 set, then set again (idempotent), with drop policy (R4)
        step(1, 1, SETC, 1, 1, 2'd1);
        step(1, 1, SETC, 1, 1, 2'd3);
        // R3 clear, R4 drop
        step(1, 1, CLRC, 1, 1, 2'd2);
        // R5 policy 0 keeps commands
        step(1, 1, SETC, 1, 1, 2'd0);
        step(1, 1, CLRC, 1, 1, 2'd0);
        // R6 data aliasing reserved values, other command values
        step(1, 0, SETC, 1, 1, 2'd1);
        step(1, 0, CLRC, 1, 1, 2'd1);
        step(1, 1, 8'hBC, 1, 1, 2'd1);
        // R7 inactive: decoder off, then FIFO off
        step(1, 1, SETC, 0, 1, 2'd1);
        step(1, 1, SETC, 1, 0, 2'd1);
        step(1, 1, SETC, 1, 1, 2'd1);
        step(1, 1, CLRC, 0, 0, 2'd2);
        step(1, 1, CLRC, 1, 0, 2'd0);
        // R8 idle cycle
        step(0, 1, SETC, 1, 1, 2'd0);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            int sel;
            sel = $urandom_range(0, 3);
            d = (sel == 0) ? SETC : (sel == 1) ? CLRC : 8'($urandom);
            step($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, d,
                 $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
                 2'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule